// File: doc/BRIEF.md
# Desaturation Fault Detector with Turn-On Blanking

This block judges whether the power switch has entered a short circuit while its gate is commanded on. It watches a gate command and a single comparator bit, already synchronized to the clock, that goes high when the collector-emitter voltage has desaturated. Each rising edge of the gate command opens a blanking window during which the comparator bit is disregarded. After the window, a persistence filter must see the bit high on a set number of consecutive cycles before the event counts as a fault.

A qualified fault produces a single-cycle trip request, meant to start a separate soft or two-level turn-off sequencer rather than a plain gate-off, together with a sticky fault flag that holds until an external clear pulse. Blanking and filter lengths are given in clock cycles. They are captured only while the gate is off, so a window already running never changes length. A configuration check flag reports when blanking plus filter time exceeds a given detection budget.

Top module: `desat_detector`

## Requirements
- R1: While reset is high and on the first sample after it, trip_o, fault_o and budget_over_o are all 0.
- R2: With blanking setting B, the comparator bit is ignored on the cycle where the gate command is first sampled high and on the B cycles after it.
- R3: With filter setting F, where the effective length Fe is F, or 1 when F is 0, a fault qualifies only when the comparator bit is high on Fe consecutive samples after blanking. A shorter run is rejected, and any low sample restarts the count from zero.
- R4: With the comparator bit held high from the turn-on edge, trip_o is high after exactly the (B+Fe)-th rising edge following the edge where the turn-on was first sampled, and not before.
- R5: trip_o is high for one cycle per fault, and no further trip is issued while fault_o stays set.
- R6: fault_o rises together with trip_o and stays set until a sample with fault_clr_i high. When a qualification and a clear arrive on the same sample, the fault stays set.
- R7: While the gate command is low, the comparator bit has no effect. Dropping the gate command for one or more cycles and raising it again restarts blanking at full length.
- R8: Blanking and filter settings are captured on every sample where the gate command is low. A change made while the gate command is high does not affect the running window.
- R9: One cycle after the settings are presented, budget_over_o is 1 if B+Fe is larger than cfg_budget_i, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_on_i | input | 1 | Gate command, 1 = switch commanded on |
| desat_i | input | 1 | Synchronized desaturation comparator bit |
| cfg_blank_i | input | BLANK_W | Blanking length in cycles |
| cfg_filt_i | input | FILT_W | Filter length in cycles, 0 behaves as 1 |
| cfg_budget_i | input | max(BLANK_W,FILT_W)+1 | Detection budget in cycles |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| trip_o | output | 1 | One-cycle trip request to the turn-off sequencer |
| fault_o | output | 1 | Sticky fault flag |
| budget_over_o | output | 1 | Blanking plus filter exceeds the budget |

## Verification
The bench builds the block with BLANK_W=5 and FILT_W=4. These narrow widths bring the full-scale blanking of 31 cycles and filter of 15 cycles within a short run, so the longest detection window is checked edge by edge next to the zero-length settings. A vector table covers spike rejection, toggle restart, clear-versus-set priority and comparator activity with the gate off. Directed runs then sweep the blank and filter pairs, change the settings during a running window, and step the budget across the B+Fe boundary.

// File: rtl/desat_pkg.sv
package desat_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BLANK = 2'd1,
    PH_ARMED = 2'd2
  } desat_phase_e;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/desat_blank_timer.sv
module desat_blank_timer
  import desat_pkg::*;
#(
  parameter int unsigned BLANK_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gate_on_i,
  input  logic [BLANK_W-1:0] cfg_blank_i,
  output desat_phase_e       phase_o
);

  logic               gate_q;
  logic [BLANK_W-1:0] blank_len_q;
  logic [BLANK_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q      <= 1'b0;
      blank_len_q <= '0;
      remain_q    <= '0;
    end else begin
      gate_q <= gate_on_i;
      if (!gate_on_i) begin
        blank_len_q <= cfg_blank_i;
        remain_q    <= '0;
      end else if (!gate_q) begin
        remain_q <= blank_len_q;
      end else if (remain_q != '0) begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (!gate_on_i)           phase_o = PH_IDLE;
    else if (!gate_q)         phase_o = PH_BLANK;
    else if (remain_q != '0)  phase_o = PH_BLANK;
    else                      phase_o = PH_ARMED;
  end

endmodule

// File: rtl/desat_persist_filter.sv
module desat_persist_filter #(
  parameter int unsigned FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_on_i,
  input  logic              armed_i,
  input  logic              desat_i,
  input  logic [FILT_W-1:0] cfg_filt_i,
  output logic              qual_o
);

  localparam logic [FILT_W-1:0] CNT_MAX = '1;

  logic [FILT_W-1:0] filt_len_q;
  logic [FILT_W-1:0] run_q;
  logic [FILT_W-1:0] need_m1;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_len_q <= '0;
      run_q      <= '0;
    end else begin
      if (!gate_on_i) filt_len_q <= cfg_filt_i;
      if (!armed_i || !desat_i) run_q <= '0;
      else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
    end
  end

  assign need_m1 = (filt_len_q == '0) ? '0 : filt_len_q - 1'b1;
  assign qual_o  = armed_i && desat_i && (run_q >= need_m1);

endmodule

// File: rtl/desat_trip_latch.sv
module desat_trip_latch (
  input  logic clk,
  input  logic rst,
  input  logic qual_i,
  input  logic clr_i,
  output logic trip_o,
  output logic fault_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      trip_o <= qual_i && !fault_o;
      if (qual_i)     fault_o <= 1'b1;
      else if (clr_i) fault_o <= 1'b0;
    end
  end

endmodule

// File: rtl/desat_detector.sv
module desat_detector
  import desat_pkg::*;
#(
  parameter int unsigned BLANK_W = 10,
  parameter int unsigned FILT_W  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  gate_on_i,
  input  logic                                  desat_i,
  input  logic [BLANK_W-1:0]                    cfg_blank_i,
  input  logic [FILT_W-1:0]                     cfg_filt_i,
  input  logic [((BLANK_W > FILT_W) ? BLANK_W : FILT_W):0] cfg_budget_i,
  input  logic                                  fault_clr_i,
  output logic                                  trip_o,
  output logic                                  fault_o,
  output logic                                  budget_over_o
);

  localparam int unsigned BUD_W = max_w(BLANK_W, FILT_W) + 1;

  desat_phase_e      phase;
  logic              armed;
  logic              qual;
  logic [FILT_W-1:0] filt_eff;
  logic [BUD_W-1:0]  window_sum;

  desat_blank_timer #(.BLANK_W(BLANK_W)) blank_i (
    .clk        (clk),
    .rst        (rst),
    .gate_on_i  (gate_on_i),
    .cfg_blank_i(cfg_blank_i),
    .phase_o    (phase)
  );

  assign armed = (phase == PH_ARMED);

  desat_persist_filter #(.FILT_W(FILT_W)) filt_i (
    .clk       (clk),
    .rst       (rst),
    .gate_on_i (gate_on_i),
    .armed_i   (armed),
    .desat_i   (desat_i),
    .cfg_filt_i(cfg_filt_i),
    .qual_o    (qual)
  );

  desat_trip_latch latch_i (
    .clk    (clk),
    .rst    (rst),
    .qual_i (qual),
    .clr_i  (fault_clr_i),
    .trip_o (trip_o),
    .fault_o(fault_o)
  );

  assign filt_eff   = (cfg_filt_i == '0) ? FILT_W'(1) : cfg_filt_i;
  assign window_sum = BUD_W'(cfg_blank_i) + BUD_W'(filt_eff);

  always_ff @(posedge clk) begin
    if (rst) budget_over_o <= 1'b0;
    else     budget_over_o <= (window_sum > cfg_budget_i);
  end

endmodule

// File: rtl/desat_detector_chk.sv
module desat_detector_chk (
  input logic clk,
  input logic rst,
  input logic gate_on_i,
  input logic desat_i,
  input logic fault_clr_i,
  input logic trip_o,
  input logic fault_o
);

  a_r5_trip_one_cycle: assert property (@(posedge clk) disable iff (rst)
    trip_o |=> !trip_o);

  a_r6_trip_sets_fault: assert property (@(posedge clk) disable iff (rst)
    trip_o |-> fault_o);

  a_r6_fault_rise_with_trip: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> trip_o);

  a_r6_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !fault_clr_i) |=> fault_o);

  a_r3_trip_needs_desat: assert property (@(posedge clk) disable iff (rst)
    trip_o |-> $past(desat_i));

  a_r2_no_trip_on_edge: assert property (@(posedge clk) disable iff (rst)
    trip_o |-> ($past(gate_on_i) && $past(gate_on_i, 2)));

endmodule

bind desat_detector desat_detector_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .gate_on_i  (gate_on_i),
  .desat_i    (desat_i),
  .fault_clr_i(fault_clr_i),
  .trip_o     (trip_o),
  .fault_o    (fault_o)
);

// File: tb/desat_detector_tb_top.sv
module desat_detector_tb_top;

  localparam int unsigned BW = 5;
  localparam int unsigned FW = 4;
  localparam int unsigned UW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          gate_on = 1'b0;
  logic          desat = 1'b0;
  logic          clr = 1'b0;
  logic [BW-1:0] cfg_blank = '0;
  logic [FW-1:0] cfg_filt = '0;
  logic [UW-1:0] cfg_budget = '0;
  logic          trip, fault, bover;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  desat_detector #(.BLANK_W(BW), .FILT_W(FW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .gate_on_i    (gate_on),
    .desat_i      (desat),
    .cfg_blank_i  (cfg_blank),
    .cfg_filt_i   (cfg_filt),
    .cfg_budget_i (cfg_budget),
    .fault_clr_i  (clr),
    .trip_o       (trip),
    .fault_o      (fault),
    .budget_over_o(bover)
  );

  // {gate, desat, clr, exp_trip, exp_fault}; blank=3, filt=2
  localparam int NV = 34;
  localparam logic [4:0] VEC [NV] = '{
    5'b00000, 5'b11000, 5'b11000, 5'b11000, 5'b11000, 5'b11000, 5'b11011, 5'b11001,
    5'b00100, 5'b10000, 5'b10000, 5'b10000, 5'b10000, 5'b11000, 5'b10000, 5'b11000,
    5'b10000, 5'b11000, 5'b11011, 5'b11001, 5'b11101, 5'b00100, 5'b11000, 5'b11000,
    5'b01000, 5'b11000, 5'b11000, 5'b11000, 5'b11000, 5'b11000, 5'b11011, 5'b00100,
    5'b01000, 5'b01000
  };

  task automatic tick(input logic g, input logic d, input logic c);
    gate_on = g; desat = d; clr = c;
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R4 window: desat high from the turn-on edge; trip only after tick B+Fe
  task automatic run_window(input int b, input int f);
    int fe;
    fe = (f == 0) ? 1 : f;
    cfg_blank = b[BW-1:0]; cfg_filt = f[FW-1:0];
    tick(1'b0, 1'b0, 1'b1);
    for (int n = 0; n <= b + fe; n++) begin
      tick(1'b1, 1'b1, 1'b0);
      chk({31'd0, trip}, (n == b + fe) ? 32'd1 : 32'd0, $sformatf("R4 B=%0d F=%0d tick %0d", b, f, n));
    end
    chk({31'd0, fault}, 32'd1, "R6 fault after window");
    tick(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg_blank = 5'd3; cfg_filt = 4'd2; cfg_budget = 6'd10;
    desat = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({29'd0, trip, fault, bover}, 32'd0, "R1 in reset");
    rst = 1'b0;
    tick(1'b0, 1'b1, 1'b0);
    chk({29'd0, trip, fault, bover}, 32'd0, "R1 after reset");

    // vector table: R2 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][4], VEC[i][3], VEC[i][2]);
      chk({31'd0, trip},  {31'd0, VEC[i][1]}, $sformatf("R2/R3/R5 trip vec %0d", i));
      chk({31'd0, fault}, {31'd0, VEC[i][0]}, $sformatf("R6/R7 fault vec %0d", i));
    end

    // R4 sweeps including zero settings and full scale
    run_window(3, 2);
    run_window(0, 1);
    run_window(0, 0);
    run_window(5, 0);
    run_window(31, 15);

    // R8: settings changed during running window are not used
    cfg_blank = 5'd2; cfg_filt = 4'd1;
    tick(1'b0, 1'b0, 1'b1);
    cfg_blank = 5'd20; cfg_filt = 4'd9;
    for (int n = 0; n <= 3; n++) begin
      tick(1'b1, 1'b1, 1'b0);
      chk({31'd0, trip}, (n == 3) ? 32'd1 : 32'd0, $sformatf("R8 mid-window change tick %0d", n));
    end
    tick(1'b0, 1'b0, 1'b1);

    // R9 budget flag around the boundary
    cfg_blank = 5'd10; cfg_filt = 4'd5; cfg_budget = 6'd14;
    tick(1'b0, 1'b0, 1'b0);
    chk({31'd0, bover}, 32'd1, "R9 10+5 over 14");
    cfg_budget = 6'd15;
    tick(1'b0, 1'b0, 1'b0);
    chk({31'd0, bover}, 32'd0, "R9 10+5 within 15");
    cfg_blank = 5'd15; cfg_filt = 4'd0; cfg_budget = 6'd15;
    tick(1'b0, 1'b0, 1'b0);
    chk({31'd0, bover}, 32'd1, "R9 15+Fe1 over 15");
    cfg_blank = 5'd31; cfg_filt = 4'd15; cfg_budget = 6'd46;
    tick(1'b0, 1'b0, 1'b0);
    chk({31'd0, bover}, 32'd0, "R9 full scale within 46");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule